// File: doc/BRIEF.md
# Bandwidth-Managed Memory Port Arbiter

This block sits in front of a single shared on-chip memory port and selects one requestor each cycle from four traffic classes: a top class for global coherence operations, a bottom class for user-initiated coherence operations, and two actively arbitrated classes in between, CPU and DMA. The grant is registered and one-hot, and no grant is issued in a cycle with no request.

CPU and DMA each carry a 3-bit priority. A lower number means higher priority. Each of them also has a starvation counter that counts the cycles it requests and loses. When a counter reaches that requestor's programmed wait limit, the requestor is forced through on the next decision, even against a higher-priority competitor. The counter stops at the limit and never wraps, whichever of the two requestors has the higher priority. A limit of zero turns forcing off for that requestor.

Priorities and wait limits arrive as plain input ports. The memory array, command payloads and any register access are outside this block.

Top module: `bwm_port_arb`

## Requirements
- R1: `gnt_o` is registered. The request inputs sampled at a clock edge decide the value that `gnt_o` shows after that edge. Bit 0 grants global coherence, bit 1 CPU, bit 2 DMA and bit 3 user coherence. At most one bit is set, and `gnt_o` is zero during reset.
- R2: A pending global coherence request is always granted, even over a forced CPU or DMA slot.
- R3: A user coherence request is granted only when none of the other three classes is requesting.
- R4: When CPU and DMA both request and neither is forced, the one with the numerically lower priority value is granted.
- R5: When CPU and DMA have equal priority values and neither is forced, DMA is granted.
- R6: Each CPU/DMA counter increments on every cycle in which its requestor requests and is not granted. When the counter has reached a nonzero limit, that requestor wins the next decision in which global coherence is idle. With a continuous higher-priority competitor, the requestor is therefore granted once every limit+1 cycles.
- R7: A counter that has reached its limit holds that value and never wraps, however long it keeps losing, including to global coherence traffic.
- R8: A counter clears to zero in any cycle in which its requestor is granted or is not requesting.
- R9: A limit of zero disables forcing for that requestor, and priority alone decides.
- R10: When CPU and DMA are both forced in the same decision, the one that did not take the previous contested forced slot wins. The first such tie after reset goes to DMA.
- R11: When no class is requesting, `gnt_o` is zero after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| glb_req_i | input | 1 | Global coherence request |
| cpu_req_i | input | 1 | CPU request |
| dma_req_i | input | 1 | DMA request |
| usr_req_i | input | 1 | User coherence request |
| cpu_prio_i | input | 3 | CPU priority, 0 highest |
| dma_prio_i | input | 3 | DMA priority, 0 highest |
| cpu_maxwait_i | input | 8 | CPU lost-cycle limit, 0 disables forcing |
| dma_maxwait_i | input | 8 | DMA lost-cycle limit, 0 disables forcing |
| gnt_o | output | 4 | Registered one-hot grant |

## Verification
A counter that wraps or fails to clear changes the spacing of the low-priority requestor's grants. That shift shows at `gnt_o` within limit+1 cycles of the faulty count. A long global coherence burst with both requestors waiting exposes wrapping: when the burst ends, a counter that held its value gives an immediate forced grant, and a wrapped one does not. A lost tie-break bit shows on the first cycle after the burst in which both requestors are forced.

// File: rtl/bwm_arb_pkg.sv
package bwm_arb_pkg;
  localparam int unsigned NUM_CLS = 4;
  localparam int unsigned PRIO_W  = 3;
  localparam int unsigned WAIT_W  = 8;

  // grant bit positions, also the fixed class order
  localparam int unsigned IDX_GLB = 0;
  localparam int unsigned IDX_CPU = 1;
  localparam int unsigned IDX_DMA = 2;
  localparam int unsigned IDX_USR = 3;

  // index of the two actively arbitrated requestors in the counter array
  localparam int unsigned CD_CPU = 0;
  localparam int unsigned CD_DMA = 1;
  localparam int unsigned NUM_CD = 2;

  typedef logic [NUM_CLS-1:0] gnt_t;
endpackage

// File: rtl/bwm_wait_cnt.sv
module bwm_wait_cnt #(
  parameter int unsigned WAIT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              win_i,
  input  logic [WAIT_W-1:0] maxwait_i,
  output logic              sat_o
);
  logic [WAIT_W-1:0] cnt_q, cnt_d;
  logic              en;

  assign en    = (maxwait_i != '0);
  assign sat_o = en && (cnt_q >= maxwait_i);

  always_comb begin
    if (!req_i || win_i || !en) cnt_d = '0;
    else if (sat_o)             cnt_d = cnt_q;   // hold, never wrap
    else                        cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !win_i && sat_o) |=> (cnt_q == $past(cnt_q))); // R7

  AST_CNT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_i || win_i) |=> (cnt_q == '0)); // R8

  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !win_i && en && !sat_o) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R6
endmodule

// File: rtl/bwm_cd_pick.sv
module bwm_cd_pick #(
  parameter int unsigned PRIO_W = 3
) (
  input  logic              cpu_req_i,
  input  logic              dma_req_i,
  input  logic              cpu_sat_i,
  input  logic              dma_sat_i,
  input  logic [PRIO_W-1:0] cpu_prio_i,
  input  logic [PRIO_W-1:0] dma_prio_i,
  input  logic              last_dma_i,
  output logic              cpu_win_o,
  output logic              dma_win_o,
  output logic              forced_o
);
  always_comb begin
    cpu_win_o = 1'b0;
    dma_win_o = 1'b0;
    if (cpu_req_i && dma_req_i) begin
      if (cpu_sat_i && dma_sat_i) begin
        if (last_dma_i) cpu_win_o = 1'b1;
        else            dma_win_o = 1'b1;
      end else if (cpu_sat_i) begin
        cpu_win_o = 1'b1;
      end else if (dma_sat_i) begin
        dma_win_o = 1'b1;
      end else if (dma_prio_i <= cpu_prio_i) begin
        dma_win_o = 1'b1;  // tie goes to DMA
      end else begin
        cpu_win_o = 1'b1;
      end
    end else if (cpu_req_i) begin
      cpu_win_o = 1'b1;
    end else if (dma_req_i) begin
      dma_win_o = 1'b1;
    end
  end

  // contested forced slot: the winner was forced against a live competitor
  assign forced_o = (cpu_win_o && cpu_sat_i && dma_req_i) ||
                    (dma_win_o && dma_sat_i && cpu_req_i);

  always_comb begin
    assert (!(cpu_win_o && dma_win_o));
  end
endmodule

// File: rtl/bwm_port_arb.sv
module bwm_port_arb
  import bwm_arb_pkg::*;
#(
  parameter int unsigned P_W = PRIO_W,
  parameter int unsigned M_W = WAIT_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           glb_req_i,
  input  logic           cpu_req_i,
  input  logic           dma_req_i,
  input  logic           usr_req_i,
  input  logic [P_W-1:0] cpu_prio_i,
  input  logic [P_W-1:0] dma_prio_i,
  input  logic [M_W-1:0] cpu_maxwait_i,
  input  logic [M_W-1:0] dma_maxwait_i,
  output logic [3:0]     gnt_o
);
  logic [NUM_CD-1:0] cd_req, cd_win, cd_sat;
  logic [M_W-1:0]    cd_maxwait [NUM_CD];
  logic              cpu_win, dma_win, forced;
  logic              last_dma_q;
  gnt_t              gnt_d, gnt_q;

  assign cd_req[CD_CPU]     = cpu_req_i;
  assign cd_req[CD_DMA]     = dma_req_i;
  assign cd_maxwait[CD_CPU] = cpu_maxwait_i;
  assign cd_maxwait[CD_DMA] = dma_maxwait_i;
  assign cd_win[CD_CPU]     = cpu_win;
  assign cd_win[CD_DMA]     = dma_win;

  for (genvar i = 0; i < NUM_CD; i++) begin : g_wait
    bwm_wait_cnt #(.WAIT_W(M_W)) u_cnt (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .req_i     (cd_req[i]),
      .win_i     (cd_win[i]),
      .maxwait_i (cd_maxwait[i]),
      .sat_o     (cd_sat[i])
    );
  end

  // global coherence masks the active pair entirely
  bwm_cd_pick #(.PRIO_W(P_W)) u_pick (
    .cpu_req_i  (cpu_req_i && !glb_req_i),
    .dma_req_i  (dma_req_i && !glb_req_i),
    .cpu_sat_i  (cd_sat[CD_CPU]),
    .dma_sat_i  (cd_sat[CD_DMA]),
    .cpu_prio_i (cpu_prio_i),
    .dma_prio_i (dma_prio_i),
    .last_dma_i (last_dma_q),
    .cpu_win_o  (cpu_win),
    .dma_win_o  (dma_win),
    .forced_o   (forced)
  );

  always_comb begin
    gnt_d = '0;
    if (glb_req_i)      gnt_d[IDX_GLB] = 1'b1;
    else if (cpu_win)   gnt_d[IDX_CPU] = 1'b1;
    else if (dma_win)   gnt_d[IDX_DMA] = 1'b1;
    else if (usr_req_i) gnt_d[IDX_USR] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gnt_q      <= '0;
      last_dma_q <= 1'b0;  // first forced tie goes to DMA
    end else begin
      gnt_q <= gnt_d;
      if (forced) last_dma_q <= dma_win;
    end
  end

  assign gnt_o = gnt_q;

  AST_GNT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_q)); // R1

  AST_IDLE_NO_GNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(glb_req_i || cpu_req_i || dma_req_i || usr_req_i) |=> (gnt_q == '0)); // R11

  AST_GLB_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    glb_req_i |=> gnt_q[IDX_GLB]); // R2

  AST_USR_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (usr_req_i && (glb_req_i || cpu_req_i || dma_req_i)) |=> !gnt_q[IDX_USR]); // R3

  AST_CPU_FORCED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!glb_req_i && cpu_req_i && cd_sat[CD_CPU] && !(dma_req_i && cd_sat[CD_DMA]))
      |=> gnt_q[IDX_CPU]); // R6

  AST_DMA_FORCED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!glb_req_i && dma_req_i && cd_sat[CD_DMA] && !(cpu_req_i && cd_sat[CD_CPU]))
      |=> gnt_q[IDX_DMA]); // R6

  AST_TIE_ALTERNATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!glb_req_i && cpu_req_i && dma_req_i && (&cd_sat))
      |=> (gnt_q[IDX_CPU] == $past(last_dma_q))); // R10
endmodule

// File: tb/bwm_port_arb_tb_top.sv
module bwm_port_arb_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  localparam logic [3:0] GG = 4'b0001, GC = 4'b0010, GD = 4'b0100, GU = 4'b1000, GZ = 4'b0000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       glb, cpu, dma, usr;
  logic [2:0] cpu_prio, dma_prio;
  logic [7:0] cpu_mw, dma_mw;
  logic [3:0] gnt;
  int         n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  bwm_port_arb dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .glb_req_i(glb), .cpu_req_i(cpu), .dma_req_i(dma), .usr_req_i(usr),
    .cpu_prio_i(cpu_prio), .dma_prio_i(dma_prio),
    .cpu_maxwait_i(cpu_mw), .dma_maxwait_i(dma_mw),
    .gnt_o(gnt)
  );

  task automatic chk(input string tag, input logic [3:0] exp);
    n_run++;
    if (gnt !== exp) begin
      n_fail++;
      $display("FAIL %s: gnt=%b expected %b at %0t", tag, gnt, exp, $time);
    end
  endtask

  task automatic set_req(input logic g, input logic c, input logic d, input logic u);
    glb = g; cpu = c; dma = d; usr = u;
  endtask

  task automatic step_chk(input string tag, input logic [3:0] exp);
    @(negedge clk);
    chk(tag, exp);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    set_req(0, 0, 0, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    set_req(1, 1, 1, 1);
    @(negedge clk);
    chk("R1 reset", GZ);
    do_reset();
  endtask

  task automatic t_idle();
    set_req(0, 0, 0, 0);
    step_chk("R11 idle", GZ);
    set_req(0, 0, 0, 1);
    step_chk("R1 latency", GU);
    set_req(0, 0, 0, 0);
    step_chk("R11 idle after req", GZ);
  endtask

  task automatic t_global();
    cpu_prio = 0; dma_prio = 0; cpu_mw = 0; dma_mw = 0;
    set_req(1, 1, 1, 1);
    for (int i = 0; i < 4; i++) step_chk("R2 global wins", GG);
  endtask

  task automatic t_user();
    set_req(0, 0, 0, 1); step_chk("R3 user alone", GU);
    set_req(0, 1, 0, 1); step_chk("R3 user vs cpu", GC);
    set_req(0, 0, 1, 1); step_chk("R3 user vs dma", GD);
    set_req(1, 0, 0, 1); step_chk("R3 user vs global", GG);
  endtask

  task automatic t_prio();
    do_reset();
    cpu_prio = 2; dma_prio = 5; cpu_mw = 0; dma_mw = 0;
    set_req(0, 1, 1, 0);
    for (int i = 0; i < 12; i++) step_chk("R4 R9 cpu higher, no forcing", GC);
    cpu_prio = 6; dma_prio = 1;
    for (int i = 0; i < 3; i++) step_chk("R4 dma higher", GD);
  endtask

  task automatic t_tie();
    do_reset();
    cpu_prio = 3; dma_prio = 3; cpu_mw = 0; dma_mw = 0;
    set_req(0, 1, 1, 0);
    for (int i = 0; i < 3; i++) step_chk("R5 tie to dma", GD);
  endtask

  task automatic t_starve();
    do_reset();
    cpu_prio = 0; dma_prio = 7; cpu_mw = 0; dma_mw = 3;
    set_req(0, 1, 1, 0);
    for (int i = 0; i < 12; i++) step_chk("R6 dma forced every 4", (i % 4 == 3) ? GD : GC);
  endtask

  task automatic t_cpu_force();
    do_reset();
    cpu_prio = 7; dma_prio = 0; cpu_mw = 2; dma_mw = 0;
    set_req(0, 1, 1, 0);
    for (int i = 0; i < 9; i++) step_chk("R6 cpu forced every 3", (i % 3 == 2) ? GC : GD);
  endtask

  task automatic t_hold();
    do_reset();
    cpu_prio = 0; dma_prio = 7; cpu_mw = 0; dma_mw = 3;
    set_req(1, 1, 1, 0);
    for (int i = 0; i < 10; i++) step_chk("R7 global burst", GG);
    set_req(0, 1, 1, 0);
    step_chk("R7 held count forces dma", GD);
    step_chk("R7 then cpu", GC);
  endtask

  task automatic t_clear();
    do_reset();
    cpu_prio = 0; dma_prio = 7; cpu_mw = 0; dma_mw = 3;
    set_req(0, 1, 1, 0);
    step_chk("R8 lose 1", GC);
    step_chk("R8 lose 2", GC);
    set_req(0, 1, 0, 0);
    step_chk("R8 dma drops", GC);
    set_req(0, 1, 1, 0);
    for (int i = 0; i < 8; i++) step_chk("R8 count restarted", (i % 4 == 3) ? GD : GC);
  endtask

  task automatic t_both();
    do_reset();
    cpu_prio = 0; dma_prio = 7; cpu_mw = 2; dma_mw = 2;
    set_req(1, 1, 1, 0);
    for (int i = 0; i < 3; i++) step_chk("R10 global fills both", GG);
    set_req(0, 1, 1, 0);
    step_chk("R10 first tie to dma", GD);
    step_chk("R10 cpu forced", GC);
    step_chk("R10 priority", GC);
    step_chk("R10 dma forced", GD);
    set_req(1, 1, 1, 0);
    for (int i = 0; i < 3; i++) step_chk("R10 global refill", GG);
    set_req(0, 1, 1, 0);
    step_chk("R10 tie alternates to cpu", GC);
    step_chk("R10 dma follows", GD);
  endtask

  initial begin
    set_req(0, 0, 0, 0);
    cpu_prio = 0; dma_prio = 0; cpu_mw = 0; dma_mw = 0;
    @(negedge clk);
    t_reset();
    t_idle();
    t_global();
    t_user();
    t_prio();
    t_tie();
    t_starve();
    t_cpu_force();
    t_hold();
    t_clear();
    t_both();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule